// File: doc/BRIEF.md
# Endian-Configurable Load Data Aligner

This block turns a raw bus word into the value a load instruction writes back to a register. It takes the word read from a 32-bit external bus, the two low address bits, an access size and a byte-order mode. It picks out the byte, halfword or word the load asked for, positions it, and presents it one clock later with a valid flag.

Byte order is chosen per access by a mode input. In little-endian numbering, byte offset k of a word sits on bus lane k (bits 8k+7:8k). In big-endian numbering, offset k sits on lane 3-k. A misaligned load is neither trapped nor split. A word load at a non-zero offset comes back rotated. A halfword load at an odd offset returns the halfword at the even offset just below it, rotated right by one byte. Bus lanes that an access does not select never influence the result.

Top module: `load_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` become 0 on that edge.
- R2: `out_valid` equals the value of `in_valid` at the previous clock edge, so every accepted access produces exactly one result one cycle later.
- R3: A word access (`in_size` = 2'b10) returns the bus word rotated right by 8 × `in_addr` bits, and this holds in either byte order. For example, 0x11223344 at offset 1 returns 0x44112233.
- R4: A halfword access (`in_size` = 2'b01) at even offset 0 or 2 with `in_big` = 0 returns lanes 1:0 or lanes 3:2 of the bus word respectively, zero-extended.
- R5: A halfword access at even offset 0 or 2 with `in_big` = 1 returns lanes 3:2 or lanes 1:0 respectively, zero-extended. For example, 0x11223344 at offset 0 returns 0x00001122.
- R6: A halfword access at an odd offset returns the halfword that R4/R5 give for the offset one lower, rotated right by 8 bits. Bits 23:8 of the result are therefore zero. For example, little-endian offset 1 of 0x11223344 returns 0x44000033.
- R7: A byte access (`in_size` = 2'b00) with `in_big` = 0 returns bus lane `in_addr` in bits 7:0, with bits 31:8 zero.
- R8: A byte access with `in_big` = 1 returns bus lane 3 − `in_addr` in bits 7:0, with bits 31:8 zero.
- R9: Bus lanes that a byte or halfword access does not select have no effect on `out_data`.
- R10: Size code 2'b11 behaves exactly like a word access.
- R11: `in_big` is taken together with each access. Back-to-back accesses with different modes each follow their own mode.
- R12: In a cycle where `in_valid` is low, `out_data` keeps its previous value. The data, address, size and mode inputs are ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An access is presented this cycle |
| in_data | input | 32 | Raw word from the external bus |
| in_addr | input | 2 | Byte offset of the access within the word |
| in_size | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| in_big | input | 1 | 1 selects big-endian byte numbering |
| out_valid | output | 1 | Result register holds a new result |
| out_data | output | 32 | Aligned, zero-extended load result |

## Verification
The hardest case to reach from the ports is a run of back-to-back accesses in which the byte order, size and offset all change every cycle. A fault in which one access's mode leaks into its neighbour's result only shows up in that case. The stimulus drives long streams with no idle cycles in between, with random modes, sizes and offsets. It also drives alternating-mode pairs on a fixed word. Random garbage on the unused lanes, and on all inputs during idle cycles, shows whether any unselected input leaks into the held result.

// File: rtl/la_pkg.sv
package la_pkg;

    localparam int LA_DW = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } la_size_e;

    typedef struct packed {
        logic             vld;
        logic [LA_DW-1:0] data;
    } la_state_t;

endpackage

// File: rtl/la_lane_pick.sv
module la_lane_pick #(
    parameter int DW = 32,
    parameter int AW = $clog2(DW / 8)
) (
    input  logic [DW-1:0] word_i,
    input  logic [AW-1:0] off_i,
    input  logic          big_i,
    output logic [7:0]    byte_o,
    output logic [15:0]   half_o
);
    localparam int NL = DW / 8;

    logic [7:0] lane [NL];

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign lane[g] = word_i[8*g +: 8];
    end

    function automatic logic [AW-1:0] phys(input logic [AW-1:0] k, input logic big);
        return big ? ~k : k;
    endfunction

    logic [AW-1:0] base_off;
    logic [7:0]    first_b;
    logic [7:0]    second_b;

    always_comb begin
        base_off = off_i;
        base_off[0] = 1'b0;
        first_b  = lane[phys(base_off, big_i)];
        second_b = lane[phys(base_off | AW'(1), big_i)];
        half_o   = big_i ? {first_b, second_b} : {second_b, first_b};
        byte_o   = lane[phys(off_i, big_i)];
    end

endmodule

// File: rtl/la_rotate.sv
module la_rotate #(
    parameter int DW = 32,
    parameter int AW = $clog2(DW / 8)
) (
    input  logic [DW-1:0] data_i,
    input  logic [AW-1:0] amt_i,
    output logic [DW-1:0] data_o
);
    logic [DW-1:0] stage [AW+1];

    assign stage[0] = data_i;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 8 * (1 << s);
        assign stage[s+1] = amt_i[s] ? {stage[s][SH-1:0], stage[s][DW-1:SH]} : stage[s];
    end

    assign data_o = stage[AW];

endmodule

// File: rtl/load_aligner.sv
module load_aligner #(
    parameter int DATA_W = la_pkg::LA_DW,
    parameter int ADDR_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_size,
    input  logic              in_big,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import la_pkg::*;

    logic [7:0]        pick_byte;
    logic [15:0]       pick_half;
    logic [DATA_W-1:0] field;
    logic [ADDR_W-1:0] rot_amt;
    logic [DATA_W-1:0] rot_out;

    la_state_t st_d, st_q;

    la_lane_pick #(.DW(DATA_W), .AW(ADDR_W)) u_pick (
        .word_i (in_data),
        .off_i  (in_addr),
        .big_i  (in_big),
        .byte_o (pick_byte),
        .half_o (pick_half)
    );

    la_rotate #(.DW(DATA_W), .AW(ADDR_W)) u_rot (
        .data_i (field),
        .amt_i  (rot_amt),
        .data_o (rot_out)
    );

    always_comb begin
        field   = in_data;
        rot_amt = in_addr;
        case (la_size_e'(in_size))
            SZ_BYTE: begin
                field   = DATA_W'(pick_byte);
                rot_amt = '0;
            end
            SZ_HALF: begin
                field   = DATA_W'(pick_half);
                rot_amt = ADDR_W'(in_addr[0]);
            end
            default: begin
                field   = in_data;
                rot_amt = in_addr;
            end
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = rot_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

endmodule

module load_aligner_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [ADDR_W-1:0] in_addr,
    input logic [1:0]        in_size,
    input logic              in_big,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_lat_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_word_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size[1]) |=> ($countones(out_data) == $countones($past(in_data))));

    p_half_even_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b01 && !in_addr[0]) |=> (out_data[DATA_W-1:16] == '0));

    p_half_odd_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b01 && in_addr[0]) |=> (out_data[DATA_W-9:8] == '0));

    p_byte_zext_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b00) |=> (out_data[DATA_W-1:8] == '0));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

endmodule

bind load_aligner load_aligner_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/load_aligner_tb.sv
module load_aligner_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_addr = '0;
    logic [1:0]  in_size = '0;
    logic        in_big = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic        vld;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] last_exp = '0;

    always #10 clk = ~clk;

    load_aligner u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_addr   (in_addr),
        .in_size   (in_size),
        .in_big    (in_big),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [7:0] mem_byte(logic [31:0] d, int k, logic be);
        int ln;
        ln = be ? 3 - k : k;
        return d[8*ln +: 8];
    endfunction

    function automatic logic [31:0] model(logic [31:0] d, int off, logic [1:0] sz, logic be);
        logic [31:0] v;
        int base;
        if (sz[1]) begin
            v = (d >> (8 * off)) | (d << (32 - 8 * off));
        end else if (sz == 2'b01) begin
            base = off & 2;
            if (be) v = {16'h0, mem_byte(d, base, be), mem_byte(d, base + 1, be)};
            else    v = {16'h0, mem_byte(d, base + 1, be), mem_byte(d, base, be)};
            if (off % 2 == 1) v = {v[7:0], v[31:8]};
        end else begin
            v = {24'h0, mem_byte(d, off, be)};
        end
        return v;
    endfunction

    task automatic access(logic [31:0] d, int off, logic [1:0] sz, logic be, string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_addr  = off[1:0];
        in_size  = sz;
        in_big   = be;
        last_exp = model(d, off, sz, be);
        e.vld = 1'b1; e.data = last_exp; e.req = req;
        sb.push_back(e);
    endtask

    task automatic check_exact(logic [31:0] d, int off, logic [1:0] sz, logic be,
                               logic [31:0] want, string req);
        n_chk++;
        if (model(d, off, sz, be) !== want) begin
            n_fail++;
            $display("FAIL %s bench model: actual %08h expected %08h", req, model(d, off, sz, be), want);
        end
        access(d, off, sz, be, req);
    endtask

    task automatic idle(int n, string req);
        exp_t e;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = $urandom;
            in_addr  = 2'($urandom);
            in_size  = 2'($urandom);
            in_big   = 1'($urandom);
            e.vld = 1'b0; e.data = last_exp; e.req = req;
            sb.push_back(e);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_chk++;
                if (out_valid !== e.vld || out_data !== e.data) begin
                    n_fail++;
                    $display("FAIL %s: actual vld=%b data=%08h expected vld=%b data=%08h",
                             e.req, out_valid, out_data, e.vld, e.data);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] w;
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 32'h0) begin
            n_fail++;
            $display("FAIL R1: actual vld=%b data=%08h expected vld=0 data=00000000", out_valid, out_data);
        end
        @(negedge clk);
        rst = 1'b0;

        // R3: word rotation, both modes
        check_exact(32'h11223344, 0, 2'b10, 1'b0, 32'h11223344, "R3");
        check_exact(32'h11223344, 1, 2'b10, 1'b0, 32'h44112233, "R3");
        check_exact(32'h11223344, 2, 2'b10, 1'b1, 32'h33441122, "R3");
        check_exact(32'h11223344, 3, 2'b10, 1'b1, 32'h22334411, "R3");
        // R10: code 11 acts as word
        check_exact(32'h11223344, 1, 2'b11, 1'b1, 32'h44112233, "R10");
        check_exact(32'h11223344, 3, 2'b11, 1'b0, 32'h22334411, "R10");
        // R4 / R5: even halfwords
        check_exact(32'h11223344, 0, 2'b01, 1'b0, 32'h00003344, "R4");
        check_exact(32'h11223344, 2, 2'b01, 1'b0, 32'h00001122, "R4");
        check_exact(32'h11223344, 0, 2'b01, 1'b1, 32'h00001122, "R5");
        check_exact(32'h11223344, 2, 2'b01, 1'b1, 32'h00003344, "R5");
        // R6: odd halfwords
        check_exact(32'h11223344, 1, 2'b01, 1'b0, 32'h44000033, "R6");
        check_exact(32'h11223344, 3, 2'b01, 1'b0, 32'h22000011, "R6");
        check_exact(32'h11223344, 1, 2'b01, 1'b1, 32'h22000011, "R6");
        check_exact(32'h11223344, 3, 2'b01, 1'b1, 32'h44000033, "R6");
        // R7 / R8: bytes
        check_exact(32'h11223344, 0, 2'b00, 1'b0, 32'h00000044, "R7");
        check_exact(32'h11223344, 3, 2'b00, 1'b0, 32'h00000011, "R7");
        check_exact(32'h11223344, 1, 2'b00, 1'b1, 32'h00000022, "R8");
        check_exact(32'h11223344, 2, 2'b00, 1'b1, 32'h00000033, "R8");

        // R12: idle cycles hold the result while inputs churn
        idle(4, "R12");

        // R9: selected lanes fixed, unused lanes random
        for (int i = 0; i < 40; i++) begin
            w = $urandom;
            access({w[31:8], 8'h5A}, 0, 2'b00, 1'b0, "R9");
            w = $urandom;
            access({8'hA5, w[23:0]}, 0, 2'b00, 1'b1, "R9");
            w = $urandom;
            access({w[31:16], 16'hBEEF}, 1, 2'b01, 1'b0, "R9");
        end

        // R11: mode flips on every access, no gaps
        for (int i = 0; i < 16; i++) begin
            access(32'hA1B2C3D4, i % 4, 2'(i / 4), 1'(i % 2), "R11");
        end

        // R2 with R11: random mix with random idle gaps
        for (int i = 0; i < 300; i++) begin
            access($urandom, int'($urandom % 4), 2'($urandom), 1'($urandom), "R2");
            if ($urandom % 4 == 0) idle(int'($urandom % 3) + 1, "R12");
        end
        idle(2, "R12");

        wait (sb.size() == 0);
        @(posedge clk);

        // R1: reset while an access is presented
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        in_data  = 32'hDEADBEEF;
        @(posedge clk);
        #5;
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 32'h0) begin
            n_fail++;
            $display("FAIL R1: actual vld=%b data=%08h expected vld=0 data=00000000", out_valid, out_data);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b0;
        repeat (2) @(posedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule